// File: doc/BRIEF.md
# Micro-TLB with Selective Invalidate

A small, fully associative translation cache built from flip-flops that sits in front of a larger joint TLB. It keeps recently used joint-TLB translations for one side of the pipeline. A data-side instance is built with eight ways and an instruction-side instance with four. A lookup compares the virtual page number and the address-space identifier (ASID) against every way at once. On a hit the physical page number and its attribute bits come back in the same cycle.

On a miss the block stalls the requester and raises a fill request to the joint TLB. It installs the returned translation into the lowest-numbered free way, or into the least recently used way when every way is valid. Joint-TLB refills that overwrite a victim entry do not touch this cache, so a translation evicted from the joint TLB can stay usable here. Only two events empty the whole cache:

- a joint-TLB write issued in flush mode;
- an explicit invalidate strobe.

Top module: `utlb_cache`

## Requirements
- R1: After reset every way is invalid: `lk_hit`, `stall` and `fill_req` are low, and any lookup misses.
- R2: A lookup that matches a valid way raises `lk_hit` in the same cycle, with that way's `lk_ppn` and `lk_attr`, and keeps `stall` low.
- R3: A way matches when its virtual page equals `lk_vpn` and either its ASID equals `lk_asid` or its global flag is set. A global way matches under every ASID.
- R4: A lookup that misses raises `stall` in the same cycle. From the next cycle `fill_req` is high and `fill_vpn` and `fill_asid` hold the missed page and ASID until the response arrives.
- R5: A cycle with `fill_valid` high while `fill_req` is high installs the returned translation. `fill_req` is low in the next cycle, and the held lookup hits from then on.
- R6: While any way is invalid, a fill goes into an invalid way and never displaces a valid translation.
- R7: When all ways are valid, a fill replaces the least recently used way. Both a hit that is held across a clock edge and an install count as a use.
- R8: A joint-TLB write with `jtlb_wr_flush` = 0 (no-invalidate mode) leaves every translation in place.
- R9: A joint-TLB write with `jtlb_wr_flush` = 1 (flush mode) invalidates every way from the next cycle.
- R10: `inv_all` invalidates every way from the next cycle, whether or not a joint-TLB write occurs.
- R11: An invalidate (R9 or R10) in the same cycle as a fill response wins. The returned translation is not installed and `fill_req` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Address-space identifier of the lookup |
| lk_hit | output | 1 | Lookup matched a valid way |
| lk_ppn | output | PPN_W | Physical page number of the hit (zero on miss) |
| lk_attr | output | ATTR_W | Attribute bits of the hit (zero on miss) |
| stall | output | 1 | Lookup missed; the requester must hold its request |
| fill_req | output | 1 | Fill request to the joint TLB |
| fill_vpn | output | VPN_W | Page being requested |
| fill_asid | output | ASID_W | ASID being requested |
| fill_valid | input | 1 | Joint-TLB response carries a translation |
| fill_ppn | input | PPN_W | Returned physical page number |
| fill_attr | input | ATTR_W | Returned attribute bits |
| fill_global | input | 1 | Returned translation is global |
| jtlb_wr | input | 1 | Joint-TLB write command issued |
| jtlb_wr_flush | input | 1 | Write mode: 1 flushes this cache, 0 keeps it |
| inv_all | input | 1 | Explicit invalidate of every way |

## Verification
The properties assume that a requester holds `lk_valid`, `lk_vpn` and `lk_asid` steady while `stall` is high. They also assume the joint TLB asserts `fill_valid` only while `fill_req` is high. The bench drives every stalled lookup to completion before changing its address. It raises `fill_valid` only in the cycle after it has seen `fill_req`, and it drops the lookup after a cancelled fill so that no stray request remains.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

   typedef enum logic {
      FS_IDLE = 1'b0,
      FS_WAIT = 1'b1
   } fill_state_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/utlb_match.sv
module utlb_match #(
   parameter int WAYS   = 8,
   parameter int VPN_W  = 19,
   parameter int ASID_W = 8
) (
   input  logic [WAYS-1:0]   ent_valid,
   input  logic [WAYS-1:0]   ent_global,
   input  logic [VPN_W-1:0]  ent_vpn  [WAYS],
   input  logic [ASID_W-1:0] ent_asid [WAYS],
   input  logic [VPN_W-1:0]  key_vpn,
   input  logic [ASID_W-1:0] key_asid,
   output logic [WAYS-1:0]   hit_vec
);

   for (genvar i = 0; i < WAYS; i++) begin : g_cmp
      logic vpn_eq;
      logic asid_ok;
      assign vpn_eq     = (ent_vpn[i] == key_vpn);
      assign asid_ok    = ent_global[i] || (ent_asid[i] == key_asid);
      assign hit_vec[i] = ent_valid[i] && vpn_eq && asid_ok;
   end

endmodule

// File: rtl/utlb_lru.sv
module utlb_lru #(
   parameter int WAYS = 8,
   localparam int IW  = $clog2(WAYS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch_en,
   input  logic [IW-1:0] touch_idx,
   output logic [IW-1:0] lru_idx
);

   // Each way carries its rank: 0 is most recent, WAYS-1 is oldest.
   // The ranks always form a permutation of 0..WAYS-1.
   logic [IW-1:0] age_q [WAYS];
   logic [IW-1:0] touched_age;

   assign touched_age = age_q[touch_idx];

   for (genvar i = 0; i < WAYS; i++) begin : g_age
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            age_q[i] <= IW'(i);
         end else if (touch_en) begin
            if (touch_idx == IW'(i))
               age_q[i] <= '0;
            else if (age_q[i] < touched_age)
               age_q[i] <= age_q[i] + 1'b1;
         end
      end
   end

   always_comb begin
      lru_idx = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (age_q[i] == IW'(WAYS - 1))
            lru_idx = IW'(i);
      end
   end

endmodule

// File: rtl/utlb_victim.sv
module utlb_victim #(
   parameter int WAYS = 8,
   localparam int IW  = $clog2(WAYS)
) (
   input  logic [WAYS-1:0] ent_valid,
   input  logic [IW-1:0]   lru_idx,
   output logic [IW-1:0]   victim_idx
);

   // Lowest-numbered free way wins; the oldest way is used only when full.
   always_comb begin
      logic found;
      found      = 1'b0;
      victim_idx = lru_idx;
      for (int i = 0; i < WAYS; i++) begin
         if (!found && !ent_valid[i]) begin
            victim_idx = IW'(i);
            found      = 1'b1;
         end
      end
   end

endmodule

// File: rtl/utlb_cache.sv
module utlb_cache
   import utlb_pkg::*;
#(
   parameter int WAYS   = 8,
   parameter int VPN_W  = 19,
   parameter int ASID_W = 8,
   parameter int PPN_W  = 20,
   parameter int ATTR_W = 6,
   localparam int IW    = $clog2(WAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              lk_hit,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic [ATTR_W-1:0] lk_attr,
   output logic              stall,
   output logic              fill_req,
   output logic [VPN_W-1:0]  fill_vpn,
   output logic [ASID_W-1:0] fill_asid,
   input  logic              fill_valid,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic [ATTR_W-1:0] fill_attr,
   input  logic              fill_global,
   input  logic              jtlb_wr,
   input  logic              jtlb_wr_flush,
   input  logic              inv_all
);

   // ---------------- elaboration checks ----------------
   if (!is_pow2(WAYS) || WAYS < 2) begin : g_bad_ways
      $error("utlb_cache: WAYS must be a power of two, at least 2");
   end
   if (VPN_W < 1 || ASID_W < 1 || PPN_W < 1 || ATTR_W < 1) begin : g_bad_width
      $error("utlb_cache: all field widths must be positive");
   end

   // ---------------- storage ----------------
   logic [WAYS-1:0]   v_q;
   logic [WAYS-1:0]   g_q;
   logic [VPN_W-1:0]  vpn_q  [WAYS];
   logic [ASID_W-1:0] asid_q [WAYS];
   logic [PPN_W-1:0]  ppn_q  [WAYS];
   logic [ATTR_W-1:0] attr_q [WAYS];

   fill_state_e       st_q;
   logic [VPN_W-1:0]  req_vpn_q;
   logic [ASID_W-1:0] req_asid_q;

   logic [WAYS-1:0]   hit_vec;
   logic [IW-1:0]     hit_idx;
   logic [PPN_W-1:0]  hit_ppn;
   logic [ATTR_W-1:0] hit_attr;
   logic [IW-1:0]     lru_idx;
   logic [IW-1:0]     victim_idx;

   logic              kill_all;
   logic              install;
   logic              use_hit;
   logic              touch_en;
   logic [IW-1:0]     touch_idx;

   // ---------------- lookup ----------------
   utlb_match #(.WAYS(WAYS), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
      .ent_valid  (v_q),
      .ent_global (g_q),
      .ent_vpn    (vpn_q),
      .ent_asid   (asid_q),
      .key_vpn    (lk_vpn),
      .key_asid   (lk_asid),
      .hit_vec    (hit_vec)
   );

   always_comb begin
      hit_idx  = '0;
      hit_ppn  = '0;
      hit_attr = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (hit_vec[i]) begin
            hit_idx  = hit_idx  | IW'(i);
            hit_ppn  = hit_ppn  | ppn_q[i];
            hit_attr = hit_attr | attr_q[i];
         end
      end
   end

   assign lk_hit  = lk_valid && (|hit_vec);
   assign lk_ppn  = lk_hit ? hit_ppn  : '0;
   assign lk_attr = lk_hit ? hit_attr : '0;
   assign stall   = lk_valid && !(|hit_vec);

   // ---------------- control ----------------
   assign kill_all = inv_all || (jtlb_wr && jtlb_wr_flush);
   assign install  = (st_q == FS_WAIT) && fill_valid && !kill_all;
   assign use_hit  = (st_q == FS_IDLE) && lk_hit;
   assign touch_en = install || use_hit;
   assign touch_idx = install ? victim_idx : hit_idx;

   assign fill_req  = (st_q == FS_WAIT);
   assign fill_vpn  = req_vpn_q;
   assign fill_asid = req_asid_q;

   utlb_lru #(.WAYS(WAYS)) u_lru (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch_en  (touch_en),
      .touch_idx (touch_idx),
      .lru_idx   (lru_idx)
   );

   utlb_victim #(.WAYS(WAYS)) u_victim (
      .ent_valid  (v_q),
      .lru_idx    (lru_idx),
      .victim_idx (victim_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= FS_IDLE;
         req_vpn_q  <= '0;
         req_asid_q <= '0;
      end else begin
         unique case (st_q)
            FS_IDLE: begin
               if (stall) begin
                  st_q       <= FS_WAIT;
                  req_vpn_q  <= lk_vpn;
                  req_asid_q <= lk_asid;
               end
            end
            FS_WAIT: begin
               if (kill_all || fill_valid)
                  st_q <= FS_IDLE;
            end
            default: st_q <= FS_IDLE;
         endcase
      end
   end

   for (genvar i = 0; i < WAYS; i++) begin : g_way
      logic wr_this;
      assign wr_this = install && (victim_idx == IW'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q[i] <= 1'b0;
         end else if (kill_all) begin
            v_q[i] <= 1'b0;
         end else if (wr_this) begin
            v_q[i] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            g_q[i]    <= 1'b0;
            vpn_q[i]  <= '0;
            asid_q[i] <= '0;
            ppn_q[i]  <= '0;
            attr_q[i] <= '0;
         end else if (wr_this) begin
            g_q[i]    <= fill_global;
            vpn_q[i]  <= req_vpn_q;
            asid_q[i] <= req_asid_q;
            ppn_q[i]  <= fill_ppn;
            attr_q[i] <= fill_attr;
         end
      end
   end

endmodule

// File: rtl/utlb_cache_chk.sv
module utlb_cache_chk #(
   parameter int VPN_W  = 19,
   parameter int ASID_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lk_valid,
   input logic              lk_hit,
   input logic              stall,
   input logic              fill_req,
   input logic [VPN_W-1:0]  fill_vpn,
   input logic [ASID_W-1:0] fill_asid,
   input logic              fill_valid,
   input logic              jtlb_wr,
   input logic              jtlb_wr_flush,
   input logic              inv_all
);

   logic kill;
   assign kill = inv_all || (jtlb_wr && jtlb_wr_flush);

   p_hit_no_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> !stall);

   p_miss_requests_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !fill_req) |=> fill_req);

   p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && !fill_valid && !kill) |=>
         (fill_req && $stable(fill_vpn) && $stable(fill_asid)));

   p_fill_completes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && fill_valid && !kill) |=> (!fill_req && (lk_valid -> lk_hit)));

   p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (jtlb_wr && jtlb_wr_flush) |=> !lk_hit);

   p_inv_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |=> !lk_hit);

   p_inv_drops_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && fill_valid && kill) |=> (!fill_req && !lk_hit));

endmodule

bind utlb_cache utlb_cache_chk #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .lk_valid      (lk_valid),
   .lk_hit        (lk_hit),
   .stall         (stall),
   .fill_req      (fill_req),
   .fill_vpn      (fill_vpn),
   .fill_asid     (fill_asid),
   .fill_valid    (fill_valid),
   .jtlb_wr       (jtlb_wr),
   .jtlb_wr_flush (jtlb_wr_flush),
   .inv_all       (inv_all)
);

// File: tb/tb_utlb_cache.sv
`timescale 1ns/1ps
module tb_utlb_cache;

   localparam int W      = 4;
   localparam int VPN_W  = 8;
   localparam int ASID_W = 4;
   localparam int PPN_W  = 8;
   localparam int ATTR_W = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              lk_valid = 1'b0;
   logic [VPN_W-1:0]  lk_vpn = '0;
   logic [ASID_W-1:0] lk_asid = '0;
   logic              lk_hit;
   logic [PPN_W-1:0]  lk_ppn;
   logic [ATTR_W-1:0] lk_attr;
   logic              stall;
   logic              fill_req;
   logic [VPN_W-1:0]  fill_vpn;
   logic [ASID_W-1:0] fill_asid;
   logic              fill_valid = 1'b0;
   logic [PPN_W-1:0]  fill_ppn = '0;
   logic [ATTR_W-1:0] fill_attr = '0;
   logic              fill_global = 1'b0;
   logic              jtlb_wr = 1'b0;
   logic              jtlb_wr_flush = 1'b0;
   logic              inv_all = 1'b0;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   utlb_cache #(.WAYS(W), .VPN_W(VPN_W), .ASID_W(ASID_W),
                .PPN_W(PPN_W), .ATTR_W(ATTR_W)) dut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
      .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_attr(lk_attr), .stall(stall),
      .fill_req(fill_req), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
      .fill_valid(fill_valid), .fill_ppn(fill_ppn), .fill_attr(fill_attr),
      .fill_global(fill_global), .jtlb_wr(jtlb_wr),
      .jtlb_wr_flush(jtlb_wr_flush), .inv_all(inv_all)
   );

   // ---------------- reference model ----------------
   bit          m_v    [W];
   bit          m_g    [W];
   int unsigned m_vpn  [W];
   int unsigned m_asid [W];
   int unsigned m_ppn  [W];
   int unsigned m_attr [W];
   int unsigned m_age  [W];

   function automatic void m_reset();
      for (int i = 0; i < W; i++) begin
         m_v[i] = 0; m_age[i] = i;
      end
   endfunction

   function automatic int m_find(int unsigned vpn, int unsigned asid);
      for (int i = 0; i < W; i++)
         if (m_v[i] && m_vpn[i] == vpn && (m_g[i] || m_asid[i] == asid))
            return i;
      return -1;
   endfunction

   function automatic void m_touch(int k);
      int unsigned a = m_age[k];
      for (int i = 0; i < W; i++)
         if (m_age[i] < a) m_age[i]++;
      m_age[k] = 0;
   endfunction

   function automatic int m_victim();
      for (int i = 0; i < W; i++)
         if (!m_v[i]) return i;
      for (int i = 0; i < W; i++)
         if (m_age[i] == W - 1) return i;
      return 0;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int unsigned act, input int unsigned exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Lookup inside one cycle, released before the next edge.
   task automatic probe(input int unsigned vpn, input int unsigned asid,
                        input string req);
      int k;
      @(posedge clk); #1;
      lk_valid = 1'b1; lk_vpn = VPN_W'(vpn); lk_asid = ASID_W'(asid);
      #1;
      k = m_find(vpn, asid);
      check(lk_hit == (k >= 0), req, "hit", lk_hit, k >= 0);
      check(stall == (k < 0), req, "stall", stall, k < 0);
      if (k >= 0) begin
         check(lk_ppn == PPN_W'(m_ppn[k]), req, "ppn", lk_ppn, m_ppn[k]);
         check(lk_attr == ATTR_W'(m_attr[k]), req, "attr", lk_attr, m_attr[k]);
      end
      lk_valid = 1'b0;
   endtask

   // Lookup held across an edge so the hit counts as a use.
   task automatic touch(input int unsigned vpn, input int unsigned asid);
      int k;
      @(posedge clk); #1;
      lk_valid = 1'b1; lk_vpn = VPN_W'(vpn); lk_asid = ASID_W'(asid);
      #1;
      k = m_find(vpn, asid);
      check(lk_hit == 1'b1 && k >= 0, "R7", "touch hit", lk_hit, 1);
      @(posedge clk); #1;
      lk_valid = 1'b0;
      if (k >= 0) m_touch(k);
   endtask

   // Miss, request, response, then hit.
   task automatic do_fill(input int unsigned vpn, input int unsigned asid,
                          input int unsigned ppn, input int unsigned attr,
                          input bit glob, input bit kill);
      int k;
      @(posedge clk); #1;
      lk_valid = 1'b1; lk_vpn = VPN_W'(vpn); lk_asid = ASID_W'(asid);
      #1;
      check(stall == 1'b1 && lk_hit == 1'b0, "R4", "miss stall", stall, 1);
      @(posedge clk); #1;
      check(fill_req == 1'b1, "R4", "fill_req", fill_req, 1);
      check(fill_vpn == VPN_W'(vpn), "R4", "fill_vpn", fill_vpn, vpn);
      check(fill_asid == ASID_W'(asid), "R4", "fill_asid", fill_asid, asid);
      fill_valid = 1'b1; fill_ppn = PPN_W'(ppn); fill_attr = ATTR_W'(attr);
      fill_global = glob; inv_all = kill;
      @(posedge clk); #1;
      fill_valid = 1'b0; inv_all = 1'b0;
      if (kill) begin
         m_reset_valid();
         check(fill_req == 1'b0, "R11", "fill_req after drop", fill_req, 0);
         check(lk_hit == 1'b0, "R11", "dropped fill hit", lk_hit, 0);
      end else begin
         k = m_victim();
         m_v[k] = 1; m_g[k] = glob; m_vpn[k] = vpn; m_asid[k] = asid;
         m_ppn[k] = ppn; m_attr[k] = attr;
         m_touch(k);
         check(fill_req == 1'b0, "R5", "fill_req after fill", fill_req, 0);
         check(lk_hit == 1'b1, "R5", "hit after fill", lk_hit, 1);
         check(lk_ppn == PPN_W'(ppn), "R5", "ppn after fill", lk_ppn, ppn);
      end
      lk_valid = 1'b0;
   endtask

   function automatic void m_reset_valid();
      for (int i = 0; i < W; i++) m_v[i] = 0;
   endfunction

   task automatic jwrite(input bit flush);
      @(posedge clk); #1;
      jtlb_wr = 1'b1; jtlb_wr_flush = flush;
      @(posedge clk); #1;
      jtlb_wr = 1'b0; jtlb_wr_flush = 1'b0;
      if (flush) m_reset_valid();
   endtask

   task automatic invalidate();
      @(posedge clk); #1;
      inv_all = 1'b1;
      @(posedge clk); #1;
      inv_all = 1'b0;
      m_reset_valid();
   endtask

   // ---------------- watchdog ----------------
   bit done = 0;
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      m_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      // R1: reset state
      check(lk_hit == 1'b0, "R1", "hit", lk_hit, 0);
      check(stall == 1'b0, "R1", "stall", stall, 0);
      check(fill_req == 1'b0, "R1", "fill_req", fill_req, 0);
      probe(8'h10, 1, "R1");

      // R6: four fills land in free ways, none displaced
      for (int i = 0; i < W; i++)
         do_fill(8'h10 + i, 1, 8'hA0 + i, i, 0, 0);
      for (int i = 0; i < W; i++) probe(8'h10 + i, 1, "R6");
      // R2 / R3: other ASID and other pages miss
      for (int i = 0; i < W; i++) probe(8'h10 + i, 2, "R3");
      probe(8'h55, 1, "R2");

      // R7: reorder uses, then a new page evicts the oldest
      touch(8'h12, 1); touch(8'h10, 1); touch(8'h13, 1); touch(8'h11, 1);
      do_fill(8'h20, 1, 8'hB0, 5, 0, 0);
      probe(8'h12, 1, "R7");
      for (int i = 0; i < W; i++) probe(8'h10 + i, 1, "R7");
      probe(8'h20, 1, "R7");

      // R3: a global entry matches every ASID
      do_fill(8'h30, 1, 8'hC3, 7, 1, 0);
      for (int a = 0; a < (1 << ASID_W); a++) probe(8'h30, a, "R3");

      // R8: write in no-invalidate mode keeps everything
      jwrite(1'b0);
      for (int v = 8'h10; v < 8'h40; v++) probe(v, 1, "R8");

      // R9: write in flush mode clears everything
      jwrite(1'b1);
      for (int v = 8'h10; v < 8'h40; v++) probe(v, 1, "R9");

      // R6: after a flush, a full set of fills all survive
      for (int i = 0; i < W; i++)
         do_fill(8'h40 + i, 3, 8'h60 + i, 2, 0, 0);
      for (int i = 0; i < W; i++) probe(8'h40 + i, 3, "R6");

      // R10: explicit invalidate with no joint-TLB write
      invalidate();
      for (int i = 0; i < W; i++) probe(8'h40 + i, 3, "R10");

      // R11: invalidate in the cycle of the fill response
      do_fill(8'h70, 4, 8'h77, 1, 0, 0);
      do_fill(8'h71, 4, 8'h78, 1, 0, 1);
      probe(8'h70, 4, "R11");
      probe(8'h71, 4, "R11");
      // R5: a later fill of the same page completes normally
      do_fill(8'h71, 4, 8'h79, 6, 0, 0);
      probe(8'h71, 4, "R5");

      // R3: near-exhaustive sweep of page and ASID against the model
      for (int i = 0; i < W - 1; i++)
         do_fill(8'h80 + i * 16, i, 8'h90 + i, i, (i == 1), 0);
      for (int v = 0; v < (1 << VPN_W); v += 4)
         for (int a = 0; a < (1 << ASID_W); a += 3)
            probe(v, a, "R3");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule